// File: doc/BRIEF.md
# Early Load In-Flight Tracker

A small associative table that follows loads issued speculatively, ahead of the real load instructions that will later claim their data. Each tracked entry holds the word address that was read, the physical register that received the data, and a tag naming the register whose producer supplied the base address. While an entry is live, stores are compared against it. A store that hits makes the early data stale, and the block then asks for a reissue into the same physical register.

An entry ends in one of three ways. It can be released silently when the real load is decoded. It can be reported for reissue after a conflicting store. It can be cleared together with every other entry of its group when the base register is written again. In the last case the physical registers are handed back through a freed-register report, so speculation that went down the wrong path is undone without re-executing any instruction. Early loads never hold a reorder-buffer slot and never commit. When every slot is occupied, the full flag is raised and further early loads are dropped.

Top module: `eload_tracker`

## Requirements
- R1: After reset the table is empty: `full`, `reissue_valid` and every bit of `free_valid` are 0.
- R2: An accepted allocation takes the lowest-numbered empty slot. `full` is 1 from the cycle after the fourth slot is filled, and only while all slots are occupied.
- R3: An allocation made while `full` is 1 is dropped. A later store to its address raises no reissue, and a later flush of its tag does not report it.
- R4: A store is compared on address bits [ADDR_W-1:2] only, so the two low bits are ignored. When it hits a live entry, `reissue_valid` is 1 in the next cycle, and `reissue_preg` gives that entry's register.
- R5: All entries hit by one store become stale. They are reported one per cycle in ascending slot order, and each reported entry's slot is empty from the following cycle.
- R6: A decode whose register matches a live entry releases that entry. No reissue or free report follows, and a later store to its address has no effect.
- R7: A redefinition of a base tag clears every occupied entry that carries the tag. In the next cycle only, `free_valid` bit i is 1 for each cleared slot i, with its register in `free_preg` bits [i*PREG_W +: PREG_W].
- R8: If a redefinition and an allocation with the same tag fall in the same cycle, the flush acts only on the older entries and the new entry survives.
- R9: A stale entry whose tag is being redefined is not presented as a reissue in that cycle or later. It is reported as freed instead.
- R10: A store in the same cycle as an allocation does not mark the entry being allocated.
- R11: A store whose word address matches no entry causes no reissue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Early load issued this cycle |
| alloc_addr | input | ADDR_W | Byte address of the early load |
| alloc_preg | input | PREG_W | Destination physical register |
| alloc_btag | input | BTAG_W | Tag of the base-address register |
| st_valid | input | 1 | Store address probe |
| st_addr | input | ADDR_W | Store byte address |
| dec_valid | input | 1 | Real load decoded with a pending early copy |
| dec_preg | input | PREG_W | Register of the decoded load's early copy |
| redef_valid | input | 1 | Base register written again |
| redef_btag | input | BTAG_W | Tag of the redefined register |
| reissue_valid | output | 1 | A stale entry needs its load reissued |
| reissue_preg | output | PREG_W | Register to reload |
| free_valid | output | ENTRIES | Per-slot freed-register strobe |
| free_preg | output | ENTRIES*PREG_W | Freed registers, one field per slot |
| full | output | 1 | All slots occupied |

## Verification
`full` and `reissue_valid` come straight from the slot states. They therefore change in the cycle after the edge that took the allocation, store or report. The one exception is the masking of R9, which follows the redefinition input in the same cycle. `free_valid` and `free_preg` are registered and hold for exactly the one cycle after the redefining edge. The bench drives inputs just after a falling edge and returns them to idle after the next falling edge. It then samples one time unit later, so every result is read one rising edge after its stimulus. The same-cycle masking check is the only one sampled while the redefinition is still applied.

// File: rtl/eload_pkg.sv
`timescale 1ns/1ps
// Shared types for the early-load tracker.
// Assumes: nothing beyond the 1800-2017 enum rules.
package eload_pkg;
    // Life cycle of one tracking slot
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_LIVE  = 2'd1,
        SLOT_STALE = 2'd2
    } slot_state_e;
endpackage

// File: rtl/eload_match.sv
`timescale 1ns/1ps
// Parallel equality compare of one key against N stored tags.
// Assumes: en gates each comparator; hits may be several.
module eload_match #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [W-1:0]        key,
    input  logic [N-1:0][W-1:0] tags,
    input  logic [N-1:0]        en,
    output logic [N-1:0]        hit
);
    // One comparator per slot
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = en[i] && (tags[i] == key);
    end
endmodule

// File: rtl/eload_pick.sv
`timescale 1ns/1ps
// Lowest-index-first selector: one-hot grant, index and any flag.
// Assumes: req may have any number of bits set.
module eload_pick #(
    parameter  int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan upward, keep the first request found
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                idx    = IW'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/eload_tracker.sv
`timescale 1ns/1ps
// Tracks early loads until their real load decodes, a store conflicts,
// or their base register is redefined.
// Assumes: one event of each kind per cycle; physical registers of live
// entries are unique; stores and decodes only see entries that already exist.
module eload_tracker
    import eload_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 32,
    parameter int PREG_W  = 7,
    parameter int BTAG_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_valid,
    input  logic [ADDR_W-1:0]         alloc_addr,
    input  logic [PREG_W-1:0]         alloc_preg,
    input  logic [BTAG_W-1:0]         alloc_btag,
    input  logic                      st_valid,
    input  logic [ADDR_W-1:0]         st_addr,
    input  logic                      dec_valid,
    input  logic [PREG_W-1:0]         dec_preg,
    input  logic                      redef_valid,
    input  logic [BTAG_W-1:0]         redef_btag,
    output logic                      reissue_valid,
    output logic [PREG_W-1:0]         reissue_preg,
    output logic [ENTRIES-1:0]        free_valid,
    output logic [ENTRIES*PREG_W-1:0] free_preg,
    output logic                      full
);
    localparam int WA_W  = ADDR_W - 2;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    slot_state_e                     state_q [ENTRIES];
    slot_state_e                     state_d [ENTRIES];
    logic [ENTRIES-1:0][WA_W-1:0]    waddr_q;
    logic [ENTRIES-1:0][PREG_W-1:0]  preg_q;
    logic [ENTRIES-1:0][BTAG_W-1:0]  btag_q;
    logic [ENTRIES-1:0][PREG_W-1:0]  fpreg_q;
    logic [ENTRIES-1:0]              fvalid_q;

    logic [ENTRIES-1:0] live, stale, used;
    logic [ENTRIES-1:0] st_hit, dec_hit, kill;
    logic [ENTRIES-1:0] rep_gnt, fs_gnt;
    logic [IDX_W-1:0]   rep_idx, fs_idx;
    logic               rep_any, fs_any, alloc_take;

    // Decode slot states into occupancy vectors
    for (genvar i = 0; i < ENTRIES; i++) begin : g_occ
        assign live[i]  = (state_q[i] == SLOT_LIVE);
        assign stale[i] = (state_q[i] == SLOT_STALE);
        assign used[i]  = live[i] || stale[i];
    end

    // Store probe against live entries on word addresses
    eload_match #(.N(ENTRIES), .W(WA_W)) u_st_cmp (
        .key  (st_addr[ADDR_W-1:2]),
        .tags (waddr_q),
        .en   (live & {ENTRIES{st_valid}}),
        .hit  (st_hit)
    );

    // Real-load decode against live entries
    eload_match #(.N(ENTRIES), .W(PREG_W)) u_dec_cmp (
        .key  (dec_preg),
        .tags (preg_q),
        .en   (live & {ENTRIES{dec_valid}}),
        .hit  (dec_hit)
    );

    // Base-register redefinition against every occupied entry
    eload_match #(.N(ENTRIES), .W(BTAG_W)) u_kill_cmp (
        .key  (redef_btag),
        .tags (btag_q),
        .en   (used & {ENTRIES{redef_valid}}),
        .hit  (kill)
    );

    // Oldest-slot stale entry that is not being flushed
    eload_pick #(.N(ENTRIES)) u_rep_pick (
        .req (stale & ~kill),
        .gnt (rep_gnt),
        .idx (rep_idx),
        .any (rep_any)
    );

    // Lowest empty slot for a new allocation
    eload_pick #(.N(ENTRIES)) u_free_pick (
        .req (~used),
        .gnt (fs_gnt),
        .idx (fs_idx),
        .any (fs_any)
    );

    assign alloc_take    = alloc_valid && fs_any;
    assign full          = !fs_any;
    assign reissue_valid = rep_any;
    assign reissue_preg  = preg_q[rep_idx];
    assign free_valid    = fvalid_q;
    assign free_preg     = fpreg_q;

    // Next slot state: flush, report, release, stale, allocate
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            state_d[i] = state_q[i];
            if (kill[i] || rep_gnt[i] || dec_hit[i]) begin
                state_d[i] = SLOT_EMPTY;
            end else if (st_hit[i]) begin
                state_d[i] = SLOT_STALE;
            end else if (alloc_take && fs_gnt[i]) begin
                state_d[i] = SLOT_LIVE;
            end
        end
    end

    // Slot state registers
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) state_q[i] <= SLOT_EMPTY;
            else        state_q[i] <= state_d[i];
        end
    end

    // Entry payload written on allocation into the chosen slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr_q <= '0;
            preg_q  <= '0;
            btag_q  <= '0;
        end else if (alloc_take) begin
            waddr_q[fs_idx] <= alloc_addr[ADDR_W-1:2];
            preg_q[fs_idx]  <= alloc_preg;
            btag_q[fs_idx]  <= alloc_btag;
        end
    end

    // One-cycle freed-register report for flushed slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fvalid_q <= '0;
            fpreg_q  <= '0;
        end else begin
            fvalid_q <= kill;
            for (int i = 0; i < ENTRIES; i++) begin
                if (kill[i]) fpreg_q[i] <= preg_q[i];
            end
        end
    end
endmodule

// File: rtl/eload_tracker_chk.sv
`timescale 1ns/1ps
// Temporal checks on the tracker, attached by bind.
// Assumes: used is the tracker's occupancy vector.
module eload_tracker_chk #(
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_valid,
    input logic               st_valid,
    input logic               dec_valid,
    input logic               redef_valid,
    input logic               reissue_valid,
    input logic               full,
    input logic [ENTRIES-1:0] free_valid,
    input logic [ENTRIES-1:0] used
);
    // R2
    alloc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !full && !dec_valid && !redef_valid && !reissue_valid)
        |=> ($countones(used) == $past($countones(used)) + 1));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !dec_valid && !redef_valid && !reissue_valid) |=> full);

    // R4
    reissue_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reissue_valid) |-> $past(st_valid));

    // R5
    reissue_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reissue_valid && !alloc_valid)
        |=> ($countones(used) < $past($countones(used))));

    // R7
    free_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !redef_valid |=> (free_valid == '0));
endmodule

bind eload_tracker eload_tracker_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_valid   (alloc_valid),
    .st_valid      (st_valid),
    .dec_valid     (dec_valid),
    .redef_valid   (redef_valid),
    .reissue_valid (reissue_valid),
    .full          (full),
    .free_valid    (free_valid),
    .used          (used)
);

// File: tb/eload_tracker_tb.sv
`timescale 1ns/1ps
module eload_tracker_tb;
    localparam int CLK_P = 10;
    localparam int N = 4, AW = 32, PW = 7, BW = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0, st_valid = 0, dec_valid = 0, redef_valid = 0;
    logic [AW-1:0] alloc_addr = '0, st_addr = '0;
    logic [PW-1:0] alloc_preg = '0, dec_preg = '0;
    logic [BW-1:0] alloc_btag = '0, redef_btag = '0;
    logic reissue_valid, full;
    logic [PW-1:0] reissue_preg;
    logic [N-1:0] free_valid;
    logic [N*PW-1:0] free_preg;
    int nchk = 0, nerr = 0;
    bit done = 0;

    eload_tracker #(.ENTRIES(N), .ADDR_W(AW), .PREG_W(PW), .BTAG_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_preg(alloc_preg), .alloc_btag(alloc_btag),
        .st_valid(st_valid), .st_addr(st_addr), .dec_valid(dec_valid), .dec_preg(dec_preg),
        .redef_valid(redef_valid), .redef_btag(redef_btag),
        .reissue_valid(reissue_valid), .reissue_preg(reissue_preg),
        .free_valid(free_valid), .free_preg(free_preg), .full(full));

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Let one rising edge take the driven inputs, then idle and settle
    task automatic step();
        @(negedge clk);
        alloc_valid = 0; st_valid = 0; dec_valid = 0; redef_valid = 0;
        #1;
    endtask

    task automatic alloc(logic [AW-1:0] a, logic [PW-1:0] p, logic [BW-1:0] t);
        alloc_valid = 1; alloc_addr = a; alloc_preg = p; alloc_btag = t;
        step();
    endtask

    task automatic store(logic [AW-1:0] a);
        st_valid = 1; st_addr = a;
        step();
    endtask

    task automatic redef(logic [BW-1:0] t);
        redef_valid = 1; redef_btag = t;
        step();
    endtask

    task automatic clear_all();
        for (int t = 0; t < 32; t++) redef(BW'(t));
        step();
    endtask

    function automatic logic [31:0] fp(int i);
        return 32'(free_preg[i*PW +: PW]);
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 full", 32'(full), 0);
        chk("R1 reissue", 32'(reissue_valid), 0);
        chk("R1 free", 32'(free_valid), 0);

        // R2 fill, R4 store with differing low bits, R5 removal
        for (int i = 0; i < N; i++) begin
            alloc(32'h100 + 16 * i, PW'(10 + i), BW'(i % 2));
            chk("R2 full progress", 32'(full), (i == N - 1) ? 1 : 0);
        end
        store(32'h123);
        chk("R4 reissue", 32'(reissue_valid), 1);
        chk("R4 preg", 32'(reissue_preg), 12);
        step();
        chk("R5 reported gone", 32'(reissue_valid), 0);
        chk("R5 slot freed", 32'(full), 0);
        clear_all();

        // R7 sweep over all tag patterns
        for (int p = 0; p < 16; p++) begin
            for (int i = 0; i < N; i++)
                alloc(32'h1000 + 64 * i, PW'(20 + i), p[i] ? BW'(5) : BW'(9));
            redef(5);
            chk("R7 mask", 32'(free_valid), 32'(p));
            for (int i = 0; i < N; i++)
                if (p[i]) chk("R7 preg", fp(i), 20 + i);
            chk("R2 full after flush", 32'(full), (p == 0) ? 1 : 0);
            step();
            chk("R7 one cycle", 32'(free_valid), 0);
            redef(9);
            chk("R7 rest", 32'(free_valid), 32'(~p & 15));
            step();
        end

        // R3 drop when full
        for (int i = 0; i < N; i++) alloc(32'h200 + 16 * i, PW'(i), 1);
        alloc(32'h300, 55, 1);
        chk("R3 full", 32'(full), 1);
        store(32'h300);
        chk("R3 dropped no reissue", 32'(reissue_valid), 0);
        redef(1);
        chk("R3 flush set", 32'(free_valid), 15);
        step();

        // R5 multiple stale reported in slot order
        alloc(32'h800, 30, 1); alloc(32'h840, 31, 1);
        alloc(32'h880, 32, 1); alloc(32'h840, 33, 1);
        store(32'h842);
        chk("R5 first", 32'(reissue_valid), 1);
        chk("R5 first preg", 32'(reissue_preg), 31);
        step();
        chk("R5 second", 32'(reissue_valid), 1);
        chk("R5 second preg", 32'(reissue_preg), 33);
        step();
        chk("R5 done", 32'(reissue_valid), 0);
        alloc(32'h900, 34, 4);
        redef(4);
        chk("R5 slot reuse", 32'(free_valid), 2);
        redef(1);
        chk("R5 left", 32'(free_valid), 5);
        step();

        // R6 decode release
        alloc(32'h400, 60, 3); alloc(32'h410, 61, 3);
        dec_valid = 1; dec_preg = 60; step();
        chk("R6 no free", 32'(free_valid), 0);
        chk("R6 no reissue", 32'(reissue_valid), 0);
        store(32'h400);
        chk("R6 released ignores store", 32'(reissue_valid), 0);
        store(32'h410);
        chk("R6 other live", 32'(reissue_preg), 61);
        step();
        redef(3);
        chk("R6 nothing left", 32'(free_valid), 0);
        step();

        // R8 flush before allocate of same tag
        alloc(32'h500, 70, 7);
        alloc_valid = 1; alloc_addr = 32'h510; alloc_preg = 71; alloc_btag = 7;
        redef_valid = 1; redef_btag = 7;
        step();
        chk("R8 old flushed", 32'(free_valid), 1);
        chk("R8 old preg", fp(0), 70);
        redef(7);
        chk("R8 new survived", 32'(free_valid), 2);
        chk("R8 new preg", fp(1), 71);
        step();

        // R9 flush masks stale reissue
        alloc(32'hA00, 40, 2); alloc(32'hA00, 41, 2);
        store(32'hA00);
        chk("R9 pre reissue", 32'(reissue_preg), 40);
        redef_valid = 1; redef_btag = 2; #1;
        chk("R9 masked same cycle", 32'(reissue_valid), 0);
        step();
        chk("R9 freed", 32'(free_valid), 3);
        chk("R9 freed preg", fp(1), 41);
        chk("R9 no later reissue", 32'(reissue_valid), 0);
        step();

        // R10 store with same-cycle allocation
        alloc_valid = 1; alloc_addr = 32'h600; alloc_preg = 80; alloc_btag = 8;
        st_valid = 1; st_addr = 32'h600;
        step();
        chk("R10 new not stale", 32'(reissue_valid), 0);
        store(32'h600);
        chk("R10 later store", 32'(reissue_preg), 80);
        step();

        // R11 non-matching word addresses
        alloc(32'h700, 90, 10);
        store(32'h704);
        chk("R11 next word", 32'(reissue_valid), 0);
        store(32'h6FC);
        chk("R11 prev word", 32'(reissue_valid), 0);
        store(32'h703);
        chk("R4 same word", 32'(reissue_preg), 90);
        step();
        chk("R5 cleared", 32'(reissue_valid), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule